// File: doc/BRIEF.md
# Multicart Address-Latch Banking Controller

This block is the memory-mapping controller of an 8-bit console multicart. A CPU write anywhere in the upper 32 KiB program window does not use the data bus. Instead, it stores the low ten bits of the write address in a configuration latch. From that latch and the live CPU address, the block drives the upper and lowest program-ROM address lines. It also gates the character-RAM write strobe and picks the nametable mirroring.

One latch bit selects between two layouts. The first is a switchable 16 KiB bank plus a fixed inner bank at the top of the window. The second is a whole-window layout that maps either one 32 KiB bank or one 16 KiB bank seen twice. A second latch bit depends on the board variant, chosen by the `VARIANT` parameter. On variant 0 it replaces the four lowest ROM address lines with four solder-pad inputs, which selects a menu. On variant 1 it forces an extra address bit for the fixed bank.

Top module: `mcart_banker`

## Requirements
- R1: On a rising `clk` edge with `romsel_n`=0 and `cpu_rw`=0, the latch takes `cpu_addr[9:0]`. An edge with `cpu_rw`=1 or `romsel_n`=1 leaves it unchanged. Latch fields by bit position: 9 layout select, 8 variant option, 7 CHR lock, 6..2 bank bits B4..B0, 1 mirroring, 0 half-bank.
- R2: With bit 9 clear, `prg_addr[16:14]` equals B2..B0 when `cpu_addr[14]`=0, and equals 3'b111 when `cpu_addr[14]`=1.
- R3: With bit 9 set and bit 0 clear, `prg_addr[16:15]` equals B2..B1 and `prg_addr[14]` follows `cpu_addr[14]`.
- R4: With bits 9 and 0 both set, `prg_addr[16:14]` equals B2..B0 for either value of `cpu_addr[14]`.
- R5: `prg_addr[18]` always equals B4. `prg_addr[17]` equals B3 except in the case given in R6.
- R6: With `VARIANT`=1 and bit 8 set, `prg_addr[17]`=1 whenever `cpu_addr[14]`=1. This holds in both layouts.
- R7: With `VARIANT`=0 and bit 8 set, `prg_addr[3:0]` equals `pad_sel`. In every other case it equals `cpu_addr[3:0]`.
- R8: `prg_addr[13:4]` always equals `cpu_addr[13:4]`.
- R9: With bit 7 set, `chr_we_n` is held at 1. With bit 7 clear, it follows `chr_we_n_in`.
- R10: `ciram_a10` follows `ppu_a10` when bit 1 is 0 (vertical mirroring) and follows `ppu_a11` when bit 1 is 1 (horizontal mirroring).
- R11: Reset clears the whole latch. After reset, `prg_addr[18:14]` is 0 when `cpu_addr[14]`=0 and 5'b00111 when `cpu_addr[14]`=1.
- R12: A new latch value only drives the outputs after the capturing edge. During the write cycle itself, the outputs still reflect the previous value, and a later write replaces every field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| romsel_n | input | 1 | Active-low program-window select |
| pad_sel | input | 4 | Solder-pad menu inputs |
| chr_we_n_in | input | 1 | Character-RAM write strobe from the video side |
| ppu_a10 | input | 1 | Video address bit 10 |
| ppu_a11 | input | 1 | Video address bit 11 |
| prg_addr | output | 19 | Program-ROM address |
| chr_we_n | output | 1 | Gated character-RAM write strobe |
| ciram_a10 | output | 1 | Nametable address bit 10 |

## Verification
A latch write and a program fetch can share one cycle. The write address itself is decoded by the mapper while the latch is still loading. The bench places write addresses whose new value maps differently from the old one. It then compares `prg_addr` before the capturing edge against the old latch value and after the edge against the new one.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

    localparam int LATCH_W  = 10;
    localparam int BANK_W   = 5;
    localparam int PRG_AW   = 19;
    localparam int CPU_AW   = 16;
    localparam int PAD_W    = 4;
    localparam int WIN_BIT  = 14;

    // Field order follows latch bit order 9..0.
    typedef struct packed {
        logic              wide_mode;
        logic              alt_opt;
        logic              chr_lock;
        logic [BANK_W-1:0] bank;
        logic              mirror_h;
        logic              half16;
    } cfg_t;

endpackage

// File: rtl/mcb_cfg_latch.sv
module mcb_cfg_latch
    import mcb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [LATCH_W-1:0] addr_bits,
    output cfg_t               cfg
);

    typedef struct packed {
        cfg_t cfg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cfg = cfg_t'(addr_bits);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.cfg;

    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg == cfg_t'($past(addr_bits))));

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg));

endmodule

// File: rtl/mcb_prg_map.sv
module mcb_prg_map
    import mcb_pkg::*;
#(
    parameter int VARIANT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              cfg,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [PAD_W-1:0]  pad_sel,
    output logic [PRG_AW-1:0] prg_addr
);

    localparam int INNER_W = 3;
    localparam int LOW_W   = PAD_W;
    localparam int MID_W   = WIN_BIT - LOW_W;

    logic              upper_half;
    logic [BANK_W-1:0] hi_bits;
    logic              force_b3;
    logic              pad_over;
    logic [LOW_W-1:0]  low_bits;

    assign upper_half = cpu_addr[WIN_BIT];

    generate
        if (VARIANT == 1) begin : g_v1
            assign force_b3 = cfg.alt_opt & upper_half;
            assign pad_over = 1'b0;
        end else begin : g_v0
            assign force_b3 = 1'b0;
            assign pad_over = cfg.alt_opt;
        end
    endgenerate

    always_comb begin
        hi_bits = cfg.bank;
        if (!cfg.wide_mode) begin
            if (upper_half) begin
                hi_bits[INNER_W-1:0] = '1;
            end
        end else if (!cfg.half16) begin
            hi_bits[0] = upper_half;
        end
        if (force_b3) begin
            hi_bits[INNER_W] = 1'b1;
        end
    end

    assign low_bits = pad_over ? pad_sel : cpu_addr[LOW_W-1:0];
    assign prg_addr = {hi_bits, cpu_addr[LOW_W+MID_W-1:LOW_W], low_bits};

    p_fixed_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.wide_mode && upper_half) |-> (prg_addr[16:14] == 3'b111));

    p_half_twice_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.wide_mode && cfg.half16) |-> (prg_addr[16:14] == cfg.bank[2:0]));

    p_top_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prg_addr[18] == cfg.bank[4]);

    generate
        if (VARIANT == 1) begin : g_a_v1
            p_force_q_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg.alt_opt && upper_half) |-> prg_addr[17]);
        end else begin : g_a_v0
            p_pads_r7: assert property (@(posedge clk) disable iff (!rst_n)
                cfg.alt_opt |-> (prg_addr[3:0] == pad_sel));
        end
    endgenerate

endmodule

// File: rtl/mcb_video_gate.sv
module mcb_video_gate
    import mcb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cfg_t cfg,
    input  logic chr_we_n_in,
    input  logic ppu_a10,
    input  logic ppu_a11,
    output logic chr_we_n,
    output logic ciram_a10
);

    assign chr_we_n  = chr_we_n_in | cfg.chr_lock;
    assign ciram_a10 = cfg.mirror_h ? ppu_a11 : ppu_a10;

    p_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.chr_lock |-> chr_we_n);

    p_vert_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.mirror_h |-> (ciram_a10 == ppu_a10));

endmodule

// File: rtl/mcart_banker.sv
module mcart_banker
    import mcb_pkg::*;
#(
    parameter int VARIANT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic              romsel_n,
    input  logic [PAD_W-1:0]  pad_sel,
    input  logic              chr_we_n_in,
    input  logic              ppu_a10,
    input  logic              ppu_a11,
    output logic [PRG_AW-1:0] prg_addr,
    output logic              chr_we_n,
    output logic              ciram_a10
);

    cfg_t cfg;
    logic wr_en;

    assign wr_en = !romsel_n && !cpu_rw;

    mcb_cfg_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr_bits (cpu_addr[LATCH_W-1:0]),
        .cfg       (cfg)
    );

    mcb_prg_map #(.VARIANT(VARIANT)) u_prg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .cpu_addr (cpu_addr),
        .pad_sel  (pad_sel),
        .prg_addr (prg_addr)
    );

    mcb_video_gate u_vid (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg         (cfg),
        .chr_we_n_in (chr_we_n_in),
        .ppu_a10     (ppu_a10),
        .ppu_a11     (ppu_a11),
        .chr_we_n    (chr_we_n),
        .ciram_a10   (ciram_a10)
    );

endmodule

// File: tb/mcart_banker_bench.sv
module mcart_banker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h8000;
    logic        cpu_rw = 1'b1;
    logic        romsel_n = 1'b1;
    logic [3:0]  pad_sel = 4'hA;
    logic        chr_we_n_in = 1'b0;
    logic        ppu_a10 = 1'b0;
    logic        ppu_a11 = 1'b1;
    logic [18:0] prg0, prg1;
    logic        we0, we1, nt0, nt1;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    mcart_banker #(.VARIANT(0)) u_mcart_banker (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
        .romsel_n(romsel_n), .pad_sel(pad_sel), .chr_we_n_in(chr_we_n_in),
        .ppu_a10(ppu_a10), .ppu_a11(ppu_a11),
        .prg_addr(prg0), .chr_we_n(we0), .ciram_a10(nt0));

    mcart_banker #(.VARIANT(1)) u_mcart_banker_v1 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
        .romsel_n(romsel_n), .pad_sel(pad_sel), .chr_we_n_in(chr_we_n_in),
        .ppu_a10(ppu_a10), .ppu_a11(ppu_a11),
        .prg_addr(prg1), .chr_we_n(we1), .ciram_a10(nt1));

    // Entry: {latch value, cpu A14, expected A18..A14 variant 0, variant 1}
    localparam logic [20:0] VEC [12] = '{
        {10'h000, 1'b0, 5'b00000, 5'b00000},
        {10'h000, 1'b1, 5'b00111, 5'b00111},
        {10'h058, 1'b0, 5'b10110, 5'b10110},
        {10'h058, 1'b1, 5'b10111, 5'b10111},
        {10'h22C, 1'b0, 5'b01010, 5'b01010},
        {10'h22C, 1'b1, 5'b01011, 5'b01011},
        {10'h229, 1'b0, 5'b01010, 5'b01010},
        {10'h229, 1'b1, 5'b01010, 5'b01010},
        {10'h108, 1'b0, 5'b00010, 5'b00010},
        {10'h108, 1'b1, 5'b00111, 5'b01111},
        {10'h310, 1'b0, 5'b00100, 5'b00100},
        {10'h310, 1'b1, 5'b00101, 5'b01101}
    };

    function automatic logic [18:0] ref_prg(int v, logic [9:0] c, logic [15:0] a,
                                            logic [3:0] pads);
        logic [18:0] r;
        r = {c[6:2], a[13:0]};
        if (!c[9]) begin
            if (a[14]) r[16:14] = 3'b111;
        end else if (!c[0]) begin
            r[14] = a[14];
        end
        if (v == 1 && c[8] && a[14]) r[17] = 1'b1;
        if (v == 0 && c[8]) r[3:0] = pads;
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [9:0] val);
        @(negedge clk);
        cpu_addr = {6'b100000, val};
        cpu_rw = 1'b0;
        romsel_n = 1'b0;
        @(negedge clk);
        cpu_rw = 1'b1;
        romsel_n = 1'b1;
    endtask

    task automatic rd(logic [15:0] a);
        cpu_addr = a;
        #2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        rd(16'h8123);
        chk("R11", prg0[18:14], 5'b00000);
        chk("R11", prg1[18:14], 5'b00000);
        rst_n = 1'b1;
        @(negedge clk);
        rd(16'h8123);
        chk("R11", prg0[18:14], 5'b00000);
        rd(16'hC123);
        chk("R11", prg0[18:14], 5'b00111);
        chk("R11", prg1[18:14], 5'b00111);
        chk("R9", we0, 1'b0);
        chk("R10", nt0, 1'b0);

        // Table: R2 R3 R4 R6
        foreach (VEC[i]) begin
            wr(VEC[i][20:11]);
            rd({1'b1, VEC[i][10], 14'h0000});
            chk("R2_R3_R4", prg0[18:14], VEC[i][9:5]);
            chk("R6", prg1[18:14], VEC[i][4:0]);
        end

        // Full sweep of latch values against the reference
        for (int c = 0; c < 1024; c++) begin
            wr(c[9:0]);
            for (int h = 0; h < 2; h++) begin
                rd({1'b1, h[0], 14'h2A35});
                chk("R5_R7_R8", prg0, ref_prg(0, c[9:0], cpu_addr, pad_sel));
                chk("R5_R6_R8", prg1, ref_prg(1, c[9:0], cpu_addr, pad_sel));
                chk("R9", we0, c[7] ? 1'b1 : chr_we_n_in);
                chk("R10", nt1, c[1] ? ppu_a11 : ppu_a10);
            end
        end

        // R7 pads only on variant 0
        wr(10'h100);
        rd(16'h8005);
        chk("R7", prg0[3:0], 4'hA);
        chk("R7", prg1[3:0], 4'h5);

        // R1 read cycle and unselected write do not load
        wr(10'h058);
        @(negedge clk);
        cpu_addr = 16'h8200; cpu_rw = 1'b1; romsel_n = 1'b0;
        @(negedge clk);
        cpu_addr = 16'h8200; cpu_rw = 1'b0; romsel_n = 1'b1;
        @(negedge clk);
        cpu_rw = 1'b1;
        rd(16'h8000);
        chk("R1", prg0[18:14], 5'b10110);

        // R12 write cycle shows old value, next cycle new value
        @(negedge clk);
        cpu_addr = 16'hC22C; cpu_rw = 1'b0; romsel_n = 1'b0;
        #2;
        chk("R12", prg0[18:14], 5'b10111);
        @(negedge clk);
        #2;
        chk("R12", prg0[18:14], 5'b01011);
        cpu_rw = 1'b1; romsel_n = 1'b1;

        // R9 / R10 with strobes toggled
        wr(10'h082);
        chr_we_n_in = 1'b0; ppu_a10 = 1'b0; ppu_a11 = 1'b1;
        #2;
        chk("R9", we0, 1'b1);
        chk("R10", nt0, 1'b1);
        wr(10'h000);
        #2;
        chk("R9", we0, 1'b0);
        chk("R10", nt0, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule